// File: doc/BRIEF.md
# Acknowledged Two-Entry Cell Output Buffer

This block sits on one output port of a pipelined, multistage cell switch. Every cycle it puts a cell on its output port toward the next stage without waiting for permission. It also keeps a copy of each cell it has sent until the next stage acknowledges that cell. Because it can hold two cells, it can always keep a cell it has already sent while it waits for the acknowledgement. This means no cell is lost when the next stage cannot take it.

Cells come in over a valid/ready handshake from the arbiter that serves the local input queues. The buffer's choice each cycle depends only on its occupancy at the start of that cycle. When both slots are taken, the buffer repeats the oldest unacknowledged cell and refuses new input. When a slot is free and a fresh cell is offered, the buffer sends that cell straight through in the same cycle and writes a copy into storage. When a slot is free and nothing is offered, the output is idle. Each acknowledgement from downstream frees the oldest stored copy. The send path, the acceptance handshake and the acknowledgement path all act in the same cycle without blocking one another.

Back-pressure: `in_ready` depends only on registered occupancy and never on `ack_in`, so there is no combinational path from downstream to upstream. A cell is taken only on a cycle where `in_valid` and `in_ready` are both high. The output has no ready signal. The next stage tells the buffer it took a cell only by raising `ack_in`.

Top module: `cell_ack_outbuf`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty`=1, `full`=0, `in_ready`=1, and `out_valid`=0 when `in_valid`=0.
- R2: `in_ready` equals the inverse of `full`. A cell is stored exactly when `in_valid` and `in_ready` are both 1 at a rising edge.
- R3: When the buffer is not full and `in_valid`=1, `out_valid`=1 and `out_data` equals `in_data` in that same cycle, and a copy becomes the newest stored cell.
- R4: When the buffer is not full and `in_valid`=0, `out_valid`=0.
- R5: When the buffer holds two cells, `out_valid`=1 and `out_data` is the oldest stored cell, whatever `in_data` holds. `in_data` is not stored, and the held cell stays unchanged until an acknowledgement arrives.
- R6: An `ack_in` pulse removes the oldest stored cell. When the buffer is empty, `ack_in` has no effect, so `empty` stays 1 and two later loads are still needed to reach `full`.
- R7: If an acknowledgement and an accepted load happen in the same cycle, both take effect. From one held cell the occupancy stays at one and the new cell becomes the oldest. From two held cells the load is refused and the occupancy drops to one.
- R8: Occupancy is never more than two. `full` is 1 exactly at two cells, `empty` is 1 exactly at zero cells, and the two are never 1 together.
- R9: Cells are kept in arrival order. After the oldest cell is acknowledged and the buffer fills again, the cell repeated on the output is the one that came in second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream offers a fresh cell |
| in_data | input | DATA_W | Fresh cell word |
| in_ready | output | 1 | Buffer can take a fresh cell this cycle |
| ack_in | input | 1 | Next stage acknowledges the oldest sent cell |
| out_valid | output | 1 | A cell is driven toward the next stage |
| out_data | output | DATA_W | Cell sent this cycle (fresh or repeated) |
| full | output | 1 | Two cells are held |
| empty | output | 1 | No cell is held |

## Verification
Two things can happen in the same cycle: an acknowledgement that frees the oldest copy, and the taking of a fresh cell that adds a copy. The bench forces this overlap on purpose in two cases. In the first, it sends a load together with an acknowledgement while one cell is held, and then checks that the occupancy does not change and that the new cell is now the oldest. In the second, it sends a cell offer together with an acknowledgement while the buffer is full, and then checks that the offer is refused, the occupancy drops to one, and the second-oldest cell becomes the one that is repeated. Random cycles with `ack_in` and `in_valid` drawn independently cause many more overlaps. A bench-side model of the two-slot order judges every cycle.

// File: rtl/cell_ack_pkg.sv
package cell_ack_pkg;
  typedef enum logic [1:0] {
    SEND_IDLE  = 2'd0,
    SEND_FRESH = 2'd1,
    SEND_HELD  = 2'd2
  } send_e;
endpackage

// File: rtl/cell_ack_occupancy.sv
module cell_ack_occupancy #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);
endmodule

// File: rtl/cell_ack_store.sv
module cell_ack_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  rd_ptr_q;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= advance(wr_ptr_q);
      if (pop)  rd_ptr_q <= advance(rd_ptr_q);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr_q == PTR_W'(g)) slot_q[g] <= wdata;
    end
  end

  assign head = slot_q[rd_ptr_q];
endmodule

// File: rtl/cell_ack_outbuf.sv
module cell_ack_outbuf
  import cell_ack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ack_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push;
  logic             pop;
  logic [CNT_W-1:0] count;
  logic [DATA_W-1:0] head;
  send_e            send;

  assign in_ready = ~full;
  assign push     = in_valid & ~full;
  assign pop      = ack_in & ~empty;

  cell_ack_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  cell_ack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (in_data),
    .head  (head)
  );

  always_comb begin
    if (full)          send = SEND_HELD;
    else if (in_valid) send = SEND_FRESH;
    else               send = SEND_IDLE;
  end

  always_comb begin
    unique case (send)
      SEND_HELD:  out_data = head;
      SEND_FRESH: out_data = in_data;
      default:    out_data = '0;
    endcase
    out_valid = (send != SEND_IDLE) && (count <= CNT_W'(DEPTH));
  end
endmodule

// File: rtl/cell_ack_outbuf_chk.sv
module cell_ack_outbuf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              ack_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              full,
  input logic              empty
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R8
  AST_FULL_SENDS: assert property (@(posedge clk) disable iff (!rst_n) full |-> (out_valid && !in_ready)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!full && !in_valid) |-> !out_valid); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (!full && in_valid) |-> (out_valid && out_data == in_data)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (full && !ack_in) |=> (full && $stable(out_data))); // R5
  AST_FILL_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (empty && in_valid && !ack_in) |=> !empty); // R2
  AST_ACK_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n) (full && ack_in) |=> (!full && !empty)); // R7
endmodule

bind cell_ack_outbuf cell_ack_outbuf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cell_ack_outbuf_test.sv
`timescale 1ns/1ps
module cell_ack_outbuf_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          ack_in = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          full;
  logic          empty;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] mq [2];
  int            mcnt = 0;

  always #2.5 clk = ~clk;

  cell_ack_outbuf #(.DATA_W(DW), .DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ack_in(ack_in), .out_valid(out_valid),
    .out_data(out_data), .full(full), .empty(empty)
  );

  function automatic logic exp_valid(input int cnt, input logic v);
    return (cnt == 2) || v;
  endfunction

  function automatic logic [DW-1:0] exp_data(input int cnt, input logic [DW-1:0] held,
                                             input logic [DW-1:0] fresh);
    return (cnt == 2) ? held : fresh;
  endfunction

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic a, input string tag);
    logic ev;
    @(negedge clk);
    in_valid = v; in_data = d; ack_in = a;
    #1;
    ev = exp_valid(mcnt, v);
    chk(tag, "out_valid", DW'(out_valid), DW'(ev));
    if (ev) chk(tag, "out_data", out_data, exp_data(mcnt, mq[0], d));
    chk(tag, "in_ready", DW'(in_ready), DW'(mcnt != 2));
    chk(tag, "full", DW'(full), DW'(mcnt == 2));
    chk(tag, "empty", DW'(empty), DW'(mcnt == 0));
    @(posedge clk);
    begin
      bit pop_m  = a && (mcnt > 0);
      bit push_m = v && (mcnt < 2);
      if (pop_m) begin mq[0] = mq[1]; mcnt--; end
      if (push_m) begin mq[mcnt] = d; mcnt++; end
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "empty", DW'(empty), 1);
    chk("R1", "full", DW'(full), 0);
    chk("R1", "in_ready", DW'(in_ready), 1);
    chk("R1", "out_valid", DW'(out_valid), 0);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    // R6: ack on empty has no effect
    step(0, 0, 1, "R6");
    step(1, 32'hA0A0_0001, 0, "R3");
    step(0, 0, 0, "R4");
    step(1, 32'hB0B0_0002, 0, "R3");
    // R5: full repeats oldest, new offer ignored
    step(1, 32'hC0C0_0003, 0, "R5");
    step(1, 32'hC0C0_0003, 0, "R5");
    // R7: ack while full, offer refused
    step(1, 32'hC0C0_0003, 1, "R7");
    step(1, 32'hD0D0_0004, 0, "R3");
    // R9: repeated cell is the second arrival
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R6");
    // R7: ack plus load from one held cell
    step(1, 32'hE0E0_0005, 1, "R7");
    step(1, 32'hF0F0_0006, 0, "R2");
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R6");
    step(0, 0, 1, "R6");
    step(0, 0, 1, "R8");
    step(1, 32'h1111_0007, 0, "R2");
    step(1, 32'h2222_0008, 0, "R8");
    for (int i = 0; i < 3000; i++) begin
      logic v = ($urandom % 100) < 60;
      logic a = ($urandom % 100) < 45;
      string tag = (mcnt == 2) ? "R5" : (v ? "R3" : "R4");
      if (a && v) tag = "R7";
      step(v, $urandom, a, tag);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule